// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration-space registers of a PCI message-signalled interrupt capability. It serves 32-bit configuration reads and writes that carry a dword address and four byte enables. A write that falls inside the capability window is merged byte by byte. Each field has its own write mask, so only legal bits change. Illegal programming is repaired at the moment the function is enabled. Reads outside the window return zero.

Parameters set the supported vector count (a power of two, 1 to 32), optional 64-bit message addressing, optional per-vector masking, and the byte offset of the capability. The layout and length of the capability follow from these options.

The block drives the enable bit, the enabled-vector field, the message address, the message data, and the mask and pending vectors to the interrupt logic. It also raises a one-cycle request to drop the legacy INTx line. The interrupt logic reports vectors that fired while masked on a pending-set input.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword 0 of the capability reads the ID 0x05 in bits 7:0 and zero in bits 15:8. The enable bit is bit 16. Bits 19:17 give log2 of the supported vector count and are read-only. Bits 22:20 are the enabled-vector field. Bit 23 is set when 64-bit addressing is supported, and bit 24 is set when per-vector masking is supported. All higher bits are zero.
- R2: In dword 0 only bit 16 and bits 22:20 accept writes. A write leaves every other bit of dword 0 unchanged.
- R3: Dword 1 is the low address, and its bits 1:0 always read zero. With 64-bit support, dword 2 is a fully writable high address, the data sits at dword 3, the mask at dword 4 and the pending bits at dword 5. Without 64-bit support, data, mask and pending sit at dwords 2, 3 and 4. The data is 16 bits in bits 15:0, with bits 31:16 reading zero. The window is 0x0A, 0x0E, 0x14 or 0x18 bytes long for the four option combinations (32/64-bit, without/with mask). The dwords it covers form the capability, and reads anywhere else return zero.
- R4: A write changes only the bytes whose byte-enable bit is set.
- R5: With masking supported, only mask bits 0 to N-1 are writable, where N is the supported vector count. Higher mask bits read zero. The pending dword cannot be written from configuration space.
- R6: With masking supported, a bit of pend_set below N sets the matching pending bit on the next clock. That bit stays set until reset or a trim (R10). pend_set bits at or above N are ignored.
- R7: Reset clears the enable bit, the enabled-vector field, both address dwords, the data, the mask and the pending bits.
- R8: After a write that hits the capability and leaves the enable bit set, an enabled-vector value above the capable value is replaced by the capable value. While disabled, the written value is kept as is.
- R9: intx_deassert is high for the one cycle after any write that hits the capability and leaves the enable bit set. It is low otherwise.
- R10: After such a write, every pending bit at or above the enabled vector count (1 << enabled-vector field) is cleared. This includes a bit set by pend_set in the same cycle.
- R11: A write outside the capability changes no register and raises no INTx request.
- R12: msi_en, msi_mme, msg_addr, msg_data, vec_mask and vec_pend present the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pend_set | input | 32 | Per-vector pending set requests |
| msi_en | output | 1 | Message interrupts enabled |
| msi_mme | output | 3 | Enabled-vector field (log2 of the count) |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| vec_pend | output | 32 | Per-vector pending bits |
| intx_deassert | output | 1 | One-cycle request to drop legacy INTx |

## Verification
A pending-set request from the interrupt logic can arrive in the same cycle as an enabling configuration write that trims the pending vector. The bench provokes this by driving pend_set together with such a write. One set bit lies inside the newly enabled vector range and one lies outside it. It then reads the pending outputs on the following cycle. There it expects the in-range bit to survive and the out-of-range bit to be dropped, with the INTx request pulsing alongside.

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter int NUM_VEC = 8,
  parameter bit ADDR64 = 1'b1,
  parameter bit PV_MASK = 1'b1,
  parameter logic [7:0] CAP_PTR = 8'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] pend_set,
  output logic        msi_en,
  output logic [2:0]  msi_mme,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_data,
  output logic [31:0] vec_mask,
  output logic [31:0] vec_pend,
  output logic        intx_deassert
);
  localparam int LOG_VEC = $clog2(NUM_VEC);
  localparam logic [2:0] MMC = 3'(LOG_VEC);
  localparam int CAP_LEN = ADDR64 ? (PV_MASK ? 24 : 14) : (PV_MASK ? 20 : 10);
  localparam int CAP_DWORDS = (CAP_LEN + 3) / 4;
  localparam logic [6:0] WIN_LO = 7'(CAP_PTR >> 2);
  localparam logic [6:0] WIN_HI = 7'(int'(CAP_PTR >> 2) + CAP_DWORDS);
  localparam logic [5:0] BASE6 = 6'(CAP_PTR >> 2);
  localparam logic [2:0] REL_DATA = ADDR64 ? 3'd3 : 3'd2;
  localparam logic [2:0] REL_MASK = REL_DATA + 3'd1;
  localparam logic [2:0] REL_PEND = REL_DATA + 3'd2;
  localparam logic [31:0] VEC_BITS = 32'((64'd1 << NUM_VEC) - 64'd1);
  localparam logic [31:0] MASK_WM = PV_MASK ? VEC_BITS : 32'h0;

  logic        en_q, en_n;
  logic [2:0]  mme_q, mme_n;
  logic [29:0] alo_q, alo_n;
  logic [31:0] ahi_q, ahi_n;
  logic [15:0] data_q, data_n;
  logic [31:0] mask_q, mask_n;
  logic [31:0] pend_q, pend_n;
  logic        intx_q;

  logic        in_win, hit;
  logic [2:0]  rel;
  logic [31:0] cur, wm, merged, keep;
  logic [6:0]  nvec;

  assign in_win = ({1'b0, cfg_addr} >= WIN_LO) && ({1'b0, cfg_addr} < WIN_HI);
  assign hit = cfg_wr && in_win;
  assign rel = 3'(cfg_addr - BASE6);

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v, input logic [31:0] wd,
                                              input logic [3:0] be, input logic [31:0] wmask);
    logic [31:0] nv;
    nv = (wd & wmask) | (old_v & ~wmask);
    merge_bytes = old_v;
    for (int i = 0; i < 4; i++)
      if (be[i]) merge_bytes[8*i +: 8] = nv[8*i +: 8];
  endfunction

  always_comb begin
    cur = 32'h0;
    wm = 32'h0;
    if (in_win) begin
      if (rel == 3'd0) begin
        cur = {7'b0, PV_MASK, ADDR64, mme_q, MMC, en_q, 16'h0005};
        wm = 32'h0071_0000;
      end else if (rel == 3'd1) begin
        cur = {alo_q, 2'b00};
        wm = 32'hFFFF_FFFC;
      end else if (ADDR64 && rel == 3'd2) begin
        cur = ahi_q;
        wm = 32'hFFFF_FFFF;
      end else if (rel == REL_DATA) begin
        cur = {16'h0, data_q};
        wm = 32'h0000_FFFF;
      end else if (PV_MASK && rel == REL_MASK) begin
        cur = mask_q;
        wm = MASK_WM;
      end else if (PV_MASK && rel == REL_PEND) begin
        cur = pend_q;
      end
    end
  end

  assign cfg_rdata = cur;
  assign merged = merge_bytes(cur, cfg_wdata, cfg_be, wm);

  always_comb begin
    en_n = en_q;
    mme_n = mme_q;
    alo_n = alo_q;
    ahi_n = ahi_q;
    data_n = data_q;
    mask_n = mask_q;
    if (hit) begin
      if (rel == 3'd0) begin
        en_n = merged[16];
        mme_n = merged[22:20];
      end else if (rel == 3'd1) begin
        alo_n = merged[31:2];
      end else if (ADDR64 && rel == 3'd2) begin
        ahi_n = merged;
      end else if (rel == REL_DATA) begin
        data_n = merged[15:0];
      end else if (PV_MASK && rel == REL_MASK) begin
        mask_n = merged;
      end
    end
    if (hit && en_n && mme_n > MMC) mme_n = MMC;
    nvec = 7'd1 << mme_n;
    keep = (hit && en_n) ? 32'((64'd1 << nvec) - 64'd1) : 32'hFFFF_FFFF;
    pend_n = PV_MASK ? ((pend_q | (pend_set & VEC_BITS)) & keep) : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      mme_q <= 3'd0;
      alo_q <= 30'd0;
      ahi_q <= 32'd0;
      data_q <= 16'd0;
      mask_q <= 32'd0;
      pend_q <= 32'd0;
      intx_q <= 1'b0;
    end else begin
      en_q <= en_n;
      mme_q <= mme_n;
      alo_q <= alo_n;
      ahi_q <= ahi_n;
      data_q <= data_n;
      mask_q <= mask_n;
      pend_q <= pend_n;
      intx_q <= hit && en_n;
    end
  end

  assign msi_en = en_q;
  assign msi_mme = mme_q;
  assign msg_addr = {(ADDR64 ? ahi_q : 32'h0), alo_q, 2'b00};
  assign msg_data = data_q;
  assign vec_mask = mask_q;
  assign vec_pend = pend_q;
  assign intx_deassert = intx_q;
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int NUM_VEC = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [31:0] pend_set,
  input logic        msi_en,
  input logic [2:0]  msi_mme,
  input logic [31:0] vec_pend,
  input logic        intx_deassert
);
  localparam logic [2:0] MMC = 3'($clog2(NUM_VEC));

  function automatic logic [31:0] kept(input logic [2:0] m);
    logic [6:0] n;
    n = 7'd1 << m;
    kept = 32'((64'd1 << n) - 64'd1);
  endfunction

  // R8
  mme_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> (msi_mme <= MMC));

  // R9
  intx_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> msi_en);

  // R10
  pend_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> ((vec_pend & ~kept(msi_mme)) == 32'h0));

  // R6
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_pend & ~$past(vec_pend) & ~$past(pend_set)) == 32'h0));

  // R11
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> ($stable(msi_en) && $stable(msi_mme) && !intx_deassert));
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .pend_set(pend_set),
  .msi_en(msi_en), .msi_mme(msi_mme), .vec_pend(vec_pend),
  .intx_deassert(intx_deassert)
);

// File: tb/msi_cap_regs_bench.sv
module msi_cap_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = 6'd0;
  logic [3:0]  cfg_be = 4'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic [31:0] pend_set = 32'd0;
  logic        msi_en;
  logic [2:0]  msi_mme;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [31:0] vec_mask;
  logic [31:0] vec_pend;
  logic        intx_deassert;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int sel;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t sq[$];

  localparam logic [5:0] B = 6'd20;

  always #5 clk = ~clk;

  msi_cap_regs u_msi_cap_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend_set(pend_set), .msi_en(msi_en),
    .msi_mme(msi_mme), .msg_addr(msg_addr), .msg_data(msg_data), .vec_mask(vec_mask),
    .vec_pend(vec_pend), .intx_deassert(intx_deassert)
  );

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: observe = cfg_rdata;
      1: observe = {31'd0, msi_en};
      2: observe = {29'd0, msi_mme};
      3: observe = msg_addr[31:0];
      4: observe = msg_addr[63:32];
      5: observe = {16'd0, msg_data};
      6: observe = vec_mask;
      7: observe = vec_pend;
      default: observe = {31'd0, intx_deassert};
    endcase
  endfunction

  always @(negedge clk) begin
    while (sq.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sq.pop_front();
      got = observe(it.sel);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic chk(int sel, logic [5:0] a, logic [31:0] e, string tag);
    item_t it;
    cfg_addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    sq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d, logic [31:0] ps);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; pend_set = ps;
    @(posedge clk); #1;
    cfg_wr = 1'b0; pend_set = 32'd0;
  endtask

  task automatic pset(logic [31:0] ps);
    @(posedge clk); #1;
    pend_set = ps;
    @(posedge clk); #1;
    pend_set = 32'd0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(0, B, 32'h0186_0005, "R1 R7 control word after reset");
    chk(1, B, 32'h0, "R7 R12 enable after reset");
    chk(7, B, 32'h0, "R7 pending after reset");
    chk(0, B + 6'd1, 32'h0, "R7 low address after reset");

    wr(B, 4'hF, 32'hFFFF_FFFF, 32'h0);
    chk(8, B, 32'h1, "R9 intx request after enabled write");
    chk(2, B, 32'h3, "R8 enabled-vector clamped");
    chk(0, B, 32'h01B7_0005, "R2 only enable and enabled-vector written");

    wr(B, 4'hC, 32'h0000_0000, 32'h0);
    chk(8, B, 32'h0, "R9 no intx when disabled");
    wr(B, 4'h4, 32'h0070_0000, 32'h0);
    chk(2, B, 32'h7, "R8 no clamp while disabled");
    chk(0, B, 32'h01F6_0005, "R1 control readback disabled");

    wr(B + 6'd1, 4'hF, 32'hFFFF_FFFF, 32'h0);
    chk(0, B + 6'd1, 32'hFFFF_FFFC, "R3 low address bits 1:0 zero");
    chk(3, B, 32'hFFFF_FFFC, "R12 msg_addr low");
    wr(B + 6'd2, 4'hF, 32'h1234_5678, 32'h0);
    chk(4, B, 32'h1234_5678, "R3 R12 high address");
    wr(B + 6'd3, 4'h1, 32'hAAAA_BEEF, 32'h0);
    chk(5, B, 32'h0000_00EF, "R4 single byte enable");
    wr(B + 6'd3, 4'hF, 32'hFFFF_CAFE, 32'h0);
    chk(0, B + 6'd3, 32'h0000_CAFE, "R3 data upper half reads zero");

    wr(B + 6'd4, 4'hF, 32'hFFFF_FFFF, 32'h0);
    chk(0, B + 6'd4, 32'h0000_00FF, "R5 mask writable width");
    wr(B + 6'd5, 4'hF, 32'hFFFF_FFFF, 32'h0);
    chk(0, B + 6'd5, 32'h0, "R5 pending not writable");

    pset(32'hFFFF_0F0F);
    chk(7, B, 32'h0000_000F, "R6 pending set limited to vectors");
    pset(32'h0);
    chk(0, B + 6'd5, 32'h0000_000F, "R6 pending sticky");

    wr(B + 6'd6, 4'hF, 32'hFFFF_FFFF, 32'h0);
    chk(8, B, 32'h0, "R11 no intx outside window");
    chk(2, B, 32'h7, "R11 enabled-vector unchanged");
    chk(0, B + 6'd6, 32'h0, "R3 read past window");
    chk(0, B - 6'd1, 32'h0, "R3 read before window");

    wr(B, 4'h4, 32'h0011_0000, 32'h0000_0010);
    chk(8, B, 32'h1, "R9 intx on enabling write");
    chk(7, B, 32'h0000_0003, "R10 trim with same-cycle set outside range");
    wr(B, 4'h4, 32'h0021_0000, 32'h0000_0024);
    chk(7, B, 32'h0000_0007, "R10 same-cycle set inside range kept");

    pset(32'h0000_0080);
    chk(7, B, 32'h0000_0087, "R10 no trim without write");
    wr(B + 6'd3, 4'h0, 32'h0, 32'h0);
    chk(8, B, 32'h1, "R9 intx on any hitting write");
    chk(7, B, 32'h0000_0007, "R10 trim on data dword write");

    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    chk(6, B, 32'h0, "R7 mask cleared by reset");
    chk(7, B, 32'h0, "R7 pending cleared by reset");
    chk(4, B, 32'h0, "R7 high address cleared");
    chk(5, B, 32'h0, "R7 data cleared");
    chk(2, B, 32'h0, "R7 enabled-vector cleared");

    @(negedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule